// File: doc/BRIEF.md
# Prefetch Outcome Classification Tracker

This block watches the lines that a hardware prefetcher brings into a private first-level cache of a multicore chip and decides, line by line, what each prefetch turned out to be worth. It keeps a valid bit and a 3-bit outcome class for every cache line index. A prefetch fill starts the class at Useless. Four kinds of event strobe, reported by the surrounding cache and coherence logic, then move the class:

- a local demand hit on the prefetched line;
- a local miss on the victim that the prefetch pushed out;
- a remote core having to upgrade a copy that the prefetch had downgraded;
- a remote core reading the line through a cache-to-cache transfer.

When the line is evicted, its final class is added to one of eight saturating counters. Software or a debug path reads one counter at a time through a select input. A second select input peeks at any line's valid bit and class.

Detection of the events themselves lies outside the block. The cache, the prefetcher and the coherence engine each drive a strobe and a line index. Several strobes may arrive in the same cycle, and they may name the same line.

Top module: `pf_outcome_tracker`

## Requirements
- R1: A fill with `fill_vld=1` and `fill_pf=1` makes the line valid with class Useless. Class codes are Useful=0, Useful/Conflict=1, Useless=2, Useless/Conflict=3, Useless/Remote=4, Useless/Conflict/Remote=5, Harmful=6 and Harmful/Conflict=7.
- R2: A demand fill (`fill_pf=0`) leaves the line not valid. Event strobes on a line that is not valid change nothing. Evicting a line that is not valid changes no counter.
- R3: A local hit (`hit_*`) on a valid line moves class 2 to class 0 and class 3 to class 1.
- R4: A victim miss (`vmiss_*`) moves class 0 to 1, class 2 to 3, class 6 to 7 and class 4 to 5.
- R5: A remote upgrade (`rupg_*`) moves class 2 to 6 and class 3 to 7.
- R6: A remote read (`rrd_*`) moves class 2 to 4 and class 3 to 5.
- R7: An event with no transition listed for the line's current class leaves the class unchanged.
- R8: Strobes that name the same line in one cycle act in the order hit, victim miss, remote upgrade, remote read. Each strobe sees the class left by the one before it.
- R9: Evicting a valid line adds one to the counter whose number equals the line's class at the start of that cycle, and makes the line not valid. Event strobes on that line in the same cycle do not alter the class that is counted.
- R10: An eviction and a fill on the same index in the same cycle count the old class first. The entry then takes the state that the fill alone would give it.
- R11: Each counter is CNT_W bits wide and stays at its all-ones value once it reaches it.
- R12: A synchronous `clr` zeroes all counters and all valid bits. It takes priority over every strobe in the same cycle.
- R13: `cnt_val` shows the counter chosen by `cnt_sel`, and `peek_valid` and `peek_cls` show the entry chosen by `peek_idx`. All three follow their select inputs without a clock. After reset, all counters read zero and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and valid bits |
| fill_vld | input | 1 | A line is filled this cycle |
| fill_pf | input | 1 | The fill was issued by the prefetcher |
| fill_idx | input | IDX_W | Line index of the fill |
| evict_vld | input | 1 | A line is evicted this cycle |
| evict_idx | input | IDX_W | Line index of the eviction |
| hit_vld | input | 1 | Local demand access to a prefetched line |
| hit_idx | input | IDX_W | Line index of the local hit |
| vmiss_vld | input | 1 | Local miss on the victim that a prefetch displaced |
| vmiss_idx | input | IDX_W | Index of the prefetched line that caused the victim |
| rupg_vld | input | 1 | A remote upgrade was forced by this line's prefetch |
| rupg_idx | input | IDX_W | Line index of the remote upgrade |
| rrd_vld | input | 1 | A remote core read the line cache-to-cache |
| rrd_idx | input | IDX_W | Line index of the remote read |
| cnt_sel | input | 3 | Selects the counter shown on `cnt_val` |
| cnt_val | output | CNT_W | Selected outcome counter |
| peek_idx | input | IDX_W | Selects the entry shown on the peek outputs |
| peek_valid | output | 1 | Valid bit of the selected entry |
| peek_cls | output | 3 | Class of the selected entry |

## Verification
Directed sequences drive one prefetched line through each legal path of the class graph. Each path ends in an eviction, so every class reaches its own counter. Repeated and out-of-order events then show that missing transitions hold the class where it is.

Single-cycle collisions separate the precedence rules from one another: all four strobes on one line, an eviction together with events, an eviction together with a refill, and a clear together with everything. A narrow counter width lets saturation be reached.

A long run of random strobes, confined to a few indices so that collisions are frequent, covers interleavings that the directed cases miss. It is compared against a behavioural model on every clock.

// File: rtl/pf_outcome_tracker.sv
module pf_outcome_tracker #(
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int NCLS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fill_vld,
  input  logic             fill_pf,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             evict_vld,
  input  logic [IDX_W-1:0] evict_idx,
  input  logic             hit_vld,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             vmiss_vld,
  input  logic [IDX_W-1:0] vmiss_idx,
  input  logic             rupg_vld,
  input  logic [IDX_W-1:0] rupg_idx,
  input  logic             rrd_vld,
  input  logic [IDX_W-1:0] rrd_idx,
  input  logic [2:0]       cnt_sel,
  output logic [CNT_W-1:0] cnt_val,
  input  logic [IDX_W-1:0] peek_idx,
  output logic             peek_valid,
  output logic [2:0]       peek_cls
);

  localparam logic [2:0] USEFUL   = 3'd0;
  localparam logic [2:0] USEFUL_C = 3'd1;
  localparam logic [2:0] USELESS  = 3'd2;
  localparam logic [2:0] USELESS_C = 3'd3;
  localparam logic [2:0] USELESS_R = 3'd4;
  localparam logic [2:0] USELESS_CR = 3'd5;
  localparam logic [2:0] HARM     = 3'd6;
  localparam logic [2:0] HARM_C   = 3'd7;

  logic [ENTRIES-1:0] vld_q;
  logic [2:0]         cls_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [NCLS];

  function automatic logic [2:0] advance(input logic [2:0] s,
                                         input logic h, input logic m,
                                         input logic u, input logic r);
    logic [2:0] n;
    n = s;
    if (h) begin
      if (n == USELESS) n = USEFUL;
      else if (n == USELESS_C) n = USEFUL_C;
    end
    if (m && n != USELESS_CR && !n[0]) n = n | 3'd1;
    if (u) begin
      if (n == USELESS) n = HARM;
      else if (n == USELESS_C) n = HARM_C;
    end
    if (r) begin
      if (n == USELESS) n = USELESS_R;
      else if (n == USELESS_C) n = USELESS_CR;
    end
    return n;
  endfunction

  wire [2:0] ev_cls = cls_q[evict_idx];
  wire       ev_cnt = evict_vld && vld_q[evict_idx] && (cnt_q[ev_cls] != {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) cls_q[i] <= USELESS;
      for (int k = 0; k < NCLS; k++) cnt_q[k] <= '0;
    end else if (clr) begin
      vld_q <= '0;
      for (int k = 0; k < NCLS; k++) cnt_q[k] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_vld && fill_idx == IDX_W'(i)) begin
          vld_q[i] <= fill_pf;
          cls_q[i] <= USELESS;
        end else if (evict_vld && evict_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b0;
        end else if (vld_q[i]) begin
          cls_q[i] <= advance(cls_q[i],
                              hit_vld   && hit_idx   == IDX_W'(i),
                              vmiss_vld && vmiss_idx == IDX_W'(i),
                              rupg_vld  && rupg_idx  == IDX_W'(i),
                              rrd_vld   && rrd_idx   == IDX_W'(i));
        end
      end
      if (ev_cnt) cnt_q[ev_cls] <= cnt_q[ev_cls] + CNT_W'(1);
    end
  end

  assign cnt_val    = cnt_q[cnt_sel];
  assign peek_valid = vld_q[peek_idx];
  assign peek_cls   = cls_q[peek_idx];

  assert_fill_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_pf && !clr) |=>
      (vld_q[$past(fill_idx)] && cls_q[$past(fill_idx)] == USELESS));

  assert_demand_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && !fill_pf && !clr) |=> !vld_q[$past(fill_idx)]);

  assert_clear_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

  for (genvar k = 0; k < NCLS; k++) begin : g_cnt_chk
    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q[k] >= $past(cnt_q[k])));
    assert_clear_cnt_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q[k] == '0));
    assert_invalid_evict_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!evict_vld || !vld_q[evict_idx]) |=> $stable(cnt_q[k]) || $past(clr));
  end

endmodule

// File: tb/pf_outcome_tracker_tb.sv
module pf_outcome_tracker_tb;
  localparam int ENT = 64;
  localparam int CW  = 4;
  localparam int IW  = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic fill_vld = 0, fill_pf = 0, evict_vld = 0;
  logic hit_vld = 0, vmiss_vld = 0, rupg_vld = 0, rrd_vld = 0;
  logic [IW-1:0] fill_idx = 0, evict_idx = 0, hit_idx = 0, vmiss_idx = 0, rupg_idx = 0, rrd_idx = 0;
  logic [2:0] cnt_sel = 0;
  logic [IW-1:0] peek_idx = 0;
  logic [CW-1:0] cnt_val;
  logic peek_valid;
  logic [2:0] peek_cls;

  pf_outcome_tracker #(.ENTRIES(ENT), .CNT_W(CW)) u_dut (.*);

  always #10 clk = ~clk;

  int mcls [ENT];
  bit mv [ENT];
  int mcnt [8];
  int vectors = 0, miscompares = 0, cyc = 0;
  int watch = 0;
  bit finished = 0;
  string tag = "R13";

  function automatic int nxt(int s, bit h, bit m, bit u, bit r);
    int n = s;
    if (h) begin
      case (n) 2: n = 0; 3: n = 1; default: ; endcase
    end
    if (m) begin
      case (n) 0: n = 1; 2: n = 3; 4: n = 5; 6: n = 7; default: ; endcase
    end
    if (u) begin
      case (n) 2: n = 6; 3: n = 7; default: ; endcase
    end
    if (r) begin
      case (n) 2: n = 4; 3: n = 5; default: ; endcase
    end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mv[i]) begin mv[i] = 0; mcls[i] = 2; end
      foreach (mcnt[k]) mcnt[k] = 0;
    end else if (clr) begin
      foreach (mv[i]) mv[i] = 0;
      foreach (mcnt[k]) mcnt[k] = 0;
    end else begin
      if (evict_vld && mv[evict_idx]) begin
        if (mcnt[mcls[evict_idx]] < MAXC) mcnt[mcls[evict_idx]]++;
        mv[evict_idx] = 0;
      end
      for (int i = 0; i < ENT; i++)
        if (mv[i] && !(fill_vld && fill_idx == i) && !(evict_vld && evict_idx == i))
          mcls[i] = nxt(mcls[i], hit_vld && hit_idx == i, vmiss_vld && vmiss_idx == i,
                        rupg_vld && rupg_idx == i, rrd_vld && rrd_idx == i);
      if (fill_vld) begin mv[fill_idx] = fill_pf; mcls[fill_idx] = 2; end
    end
  end

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_line(int i);
    chk($sformatf("valid[%0d]", i), int'(peek_valid), int'(mv[i]));
    if (mv[i]) chk($sformatf("class[%0d]", i), int'(peek_cls), mcls[i]);
  endtask

  task automatic idle();
    fill_vld = 0; evict_vld = 0; hit_vld = 0; vmiss_vld = 0; rupg_vld = 0; rrd_vld = 0; clr = 0;
  endtask

  task automatic tick();
    cnt_sel = 3'(cyc % 8);
    peek_idx = IW'(watch);
    #5;
    chk($sformatf("counter %0d", cyc % 8), int'(cnt_val), mcnt[cyc % 8]);
    cmp_line(watch);
    cyc++;
    @(negedge clk);
    idle();
  endtask

  task automatic sweep();
    for (int k = 0; k < 8; k++) begin
      cnt_sel = 3'(k); #1;
      chk($sformatf("counter %0d", k), int'(cnt_val), mcnt[k]);
    end
    for (int i = 0; i < ENT; i++) begin
      peek_idx = IW'(i); #1;
      cmp_line(i);
    end
    @(negedge clk);
  endtask

  task automatic pf(int i); fill_vld = 1; fill_pf = 1; fill_idx = IW'(i); endtask
  task automatic ev(int i); evict_vld = 1; evict_idx = IW'(i); endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R13"; sweep();

    tag = "R1"; watch = 5; pf(5); tick(); tick();
    tag = "R3"; hit_vld = 1; hit_idx = 5; tick(); tick();
    tag = "R7"; hit_vld = 1; hit_idx = 5; rupg_vld = 1; rupg_idx = 5; tick(); tick();

    tag = "R4"; watch = 6; pf(6); tick(); vmiss_vld = 1; vmiss_idx = 6; tick(); tick();
    tag = "R3"; hit_vld = 1; hit_idx = 6; tick(); tick();
    tag = "R7"; vmiss_vld = 1; vmiss_idx = 6; tick(); tick();

    tag = "R5"; watch = 7; pf(7); tick(); rupg_vld = 1; rupg_idx = 7; tick(); tick();
    tag = "R4"; vmiss_vld = 1; vmiss_idx = 7; tick(); tick();
    tag = "R5"; watch = 8; pf(8); tick(); vmiss_vld = 1; vmiss_idx = 8; tick();
    rupg_vld = 1; rupg_idx = 8; tick(); tick();

    tag = "R6"; watch = 9; pf(9); tick(); rrd_vld = 1; rrd_idx = 9; tick(); tick();
    tag = "R4"; vmiss_vld = 1; vmiss_idx = 9; tick(); tick();
    tag = "R6"; watch = 10; pf(10); tick(); vmiss_vld = 1; vmiss_idx = 10; tick();
    rrd_vld = 1; rrd_idx = 10; tick(); tick();
    tag = "R7"; rrd_vld = 1; rrd_idx = 5; hit_vld = 1; hit_idx = 9; tick(); sweep();

    tag = "R9";
    for (int i = 5; i <= 9; i++) begin watch = i; ev(i); tick(); end
    watch = 10; ev(10); hit_vld = 1; hit_idx = 10; tick(); tick();
    sweep();

    tag = "R2"; watch = 11; fill_vld = 1; fill_pf = 0; fill_idx = 11; tick();
    hit_vld = 1; hit_idx = 11; rrd_vld = 1; rrd_idx = 11; tick();
    ev(11); tick(); sweep();

    tag = "R8"; watch = 12; pf(12); tick();
    hit_vld = 1; hit_idx = 12; vmiss_vld = 1; vmiss_idx = 12;
    rupg_vld = 1; rupg_idx = 12; rrd_vld = 1; rrd_idx = 12; tick(); tick();
    watch = 13; pf(13); tick();
    vmiss_vld = 1; vmiss_idx = 13; rrd_vld = 1; rrd_idx = 13; tick(); tick();

    tag = "R10"; watch = 12; ev(12); pf(12); tick(); tick(); sweep();
    ev(13); fill_vld = 1; fill_pf = 0; fill_idx = 13; watch = 13; tick(); tick(); sweep();

    tag = "R11"; watch = 3;
    for (int n = 0; n < 20; n++) begin pf(3); tick(); ev(3); tick(); end
    sweep();

    tag = "mixed";
    for (int n = 0; n < 3000; n++) begin
      watch = $urandom_range(0, 7);
      if ($urandom_range(0, 3) == 0) begin
        fill_vld = 1; fill_pf = ($urandom_range(0, 3) != 0); fill_idx = IW'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 5) == 0) ev($urandom_range(0, 7));
      hit_vld = ($urandom_range(0, 2) == 0); hit_idx = IW'($urandom_range(0, 7));
      vmiss_vld = ($urandom_range(0, 2) == 0); vmiss_idx = IW'($urandom_range(0, 7));
      rupg_vld = ($urandom_range(0, 3) == 0); rupg_idx = IW'($urandom_range(0, 7));
      rrd_vld = ($urandom_range(0, 3) == 0); rrd_idx = IW'($urandom_range(0, 7));
      tick();
    end
    sweep();

    tag = "R12"; watch = 4; pf(4); tick();
    clr = 1; ev(4); pf(2); hit_vld = 1; hit_idx = 4; tick(); tick(); sweep();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule